// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block turns 64 general-purpose input pins into one interrupt line. Each pin is first passed through a two-stage synchroniser. It is then watched in one of two ways. In level mode it reports a high or a low level. In edge mode it reports a rising edge, a falling edge or both edges. Edge events are held in a latched raw status until software clears them. Level sources skip the latch and go straight into the masked status. A per-pin mask and a single global enable decide whether a source reaches the combined interrupt output.

Software works the block through a simple word-addressed register bus. Every per-pin setting takes two 32-bit words. Pins 0-31 sit at the base offset and pins 32-63 sit at base + 4. Reads are registered. Read data appears one cycle after the read strobe and holds until the next read. The reset input is asynchronous and active low. Its release is expected to be synchronised outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every control word, the raw status, the masked status and `irq_o` are 0, and reading any address from 0x00 to 0x4C returns 0 while the pins are low.
- R2: Bit 0 of the word at 0x00 is the global enable. While it is 0, `irq_o` stays 0, but the masked status still reports sources.
- R3: In the mode words at 0x10 (pins 0-31) and 0x14 (pins 32-63), a 1 makes the pin edge-sensitive and a 0 makes it level-sensitive.
- R4: In the dual-edge words at 0x18/0x1C, a 1 makes an edge-mode pin latch on both rising and falling transitions.
- R5: In the polarity words at 0x20/0x24, a 1 selects rising edge or high level, and a 0 selects falling edge or low level.
- R6: In the enable-mask words at 0x28/0x2C, a 1 lets the pin's source into the masked status, and a 0 blocks it.
- R7: Writing 1 to a bit of the clear words at 0x30/0x34 clears that pin's latched edge. Writing 0 leaves the bit alone. These words read back as 0.
- R8: The raw status at 0x38/0x3C latches only the configured edges of edge-mode pins. Level-mode pins never set it.
- R9: The masked status at 0x40/0x44 is the mask ANDed with the latched edge (edge pins) or the active level (level pins).
- R10: The pin words at 0x48/0x4C return each pin's value after two flops of synchronisation.
- R11: When an edge is detected in the same cycle as a clear write to that pin, the latch stays set.
- R12: `irq_o` is a register. It equals the global enable ANDed with the OR of all masked status bits, taken one cycle earlier.
- R13: `rdata` updates only on a cycle with `rd_en` high and holds otherwise. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 64 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check four things. `irq_o` never rises without the global enable. A newly latched raw bit always belongs to an edge-mode pin. A clear write removes a latched bit unless an edge arrives in that same cycle, and a detected edge always lands in the latch. Read data holds between read strobes. The bench's scenarios are needed for the rest. They show which edge or level each mix of mode, dual-edge and polarity settings reacts to. They show the split of pins between the low and high words, the synchroniser delay seen through the pin readback, and the exact cycle in which an edge and a clear collide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFF_GEN  = 'h00;
  localparam int OFF_MODE = 'h10;
  localparam int OFF_DUAL = 'h18;
  localparam int OFF_POL  = 'h20;
  localparam int OFF_MSK  = 'h28;
  localparam int OFF_CLR  = 'h30;
  localparam int OFF_RAW  = 'h38;
  localparam int OFF_MIS  = 'h40;
  localparam int OFF_PIN  = 'h48;
  localparam int BANK_STRIDE = 4;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic                gen_o,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] dual_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] msk_o,
  output logic [NUM_PINS-1:0] clr_o
);
  localparam int BANKS = NUM_PINS / WORD_W;

  logic                gen_q, gen_d;
  logic [NUM_PINS-1:0] mode_q, mode_d, dual_q, dual_d;
  logic [NUM_PINS-1:0] pol_q, pol_d, msk_q, msk_d, clr_d;

  always_comb begin
    gen_d  = gen_q;
    mode_d = mode_q;
    dual_d = dual_q;
    pol_d  = pol_q;
    msk_d  = msk_q;
    clr_d  = '0;
    if (wr_en) begin
      if (addr == ADDR_W'(OFF_GEN)) gen_d = wdata[0];
      for (int b = 0; b < BANKS; b++) begin
        if (addr == ADDR_W'(OFF_MODE + BANK_STRIDE*b)) mode_d[b*WORD_W +: WORD_W] = wdata;
        if (addr == ADDR_W'(OFF_DUAL + BANK_STRIDE*b)) dual_d[b*WORD_W +: WORD_W] = wdata;
        if (addr == ADDR_W'(OFF_POL  + BANK_STRIDE*b)) pol_d[b*WORD_W +: WORD_W]  = wdata;
        if (addr == ADDR_W'(OFF_MSK  + BANK_STRIDE*b)) msk_d[b*WORD_W +: WORD_W]  = wdata;
        if (addr == ADDR_W'(OFF_CLR  + BANK_STRIDE*b)) clr_d[b*WORD_W +: WORD_W]  = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      mode_q <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      msk_q  <= '0;
    end else if (wr_en) begin
      gen_q  <= gen_d;
      mode_q <= mode_d;
      dual_q <= dual_d;
      pol_q  <= pol_d;
      msk_q  <= msk_d;
    end
  end

  assign gen_o  = gen_q;
  assign mode_o = mode_q;
  assign dual_o = dual_q;
  assign pol_o  = pol_q;
  assign msk_o  = msk_q;
  assign clr_o  = clr_d;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0] dual_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] msk_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] hit_o,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] mis_o
);
  logic [NUM_PINS-1:0] raw_q, raw_d;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic up, down, sel_edge, lvl_act;
    always_comb begin
      up       = lvl_i[gi] & ~prev_i[gi];
      down     = ~lvl_i[gi] & prev_i[gi];
      sel_edge = dual_i[gi] ? (up | down) : (pol_i[gi] ? up : down);
      lvl_act  = pol_i[gi] ? lvl_i[gi] : ~lvl_i[gi];
      hit_o[gi] = mode_i[gi] & sel_edge;
      raw_d[gi] = hit_o[gi] | (raw_q[gi] & ~clr_i[gi]);
      mis_o[gi] = msk_i[gi] & (mode_i[gi] ? raw_q[gi] : lvl_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                irq_o
);
  localparam int BANKS = NUM_PINS / WORD_W;

  logic                gen_w;
  logic [NUM_PINS-1:0] lvl_w, prev_w, mode_w, dual_w, pol_w, msk_w, clr_w;
  logic [NUM_PINS-1:0] hit_w, raw_w, mis_w;
  logic [WORD_W-1:0]   rd_d, rd_q;
  logic                irq_d, irq_q;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl_w), .prev_o(prev_w)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .gen_o(gen_w), .mode_o(mode_w), .dual_o(dual_w), .pol_o(pol_w),
    .msk_o(msk_w), .clr_o(clr_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .prev_i(prev_w), .mode_i(mode_w),
    .dual_i(dual_w), .pol_i(pol_w), .msk_i(msk_w), .clr_i(clr_w),
    .hit_o(hit_w), .raw_o(raw_w), .mis_o(mis_w)
  );

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(OFF_GEN)) rd_d = WORD_W'(gen_w);
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(OFF_MODE + BANK_STRIDE*b)) rd_d = mode_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_DUAL + BANK_STRIDE*b)) rd_d = dual_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_POL  + BANK_STRIDE*b)) rd_d = pol_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_MSK  + BANK_STRIDE*b)) rd_d = msk_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_RAW  + BANK_STRIDE*b)) rd_d = raw_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_MIS  + BANK_STRIDE*b)) rd_d = mis_w[b*WORD_W +: WORD_W];
      if (addr == ADDR_W'(OFF_PIN  + BANK_STRIDE*b)) rd_d = lvl_w[b*WORD_W +: WORD_W];
    end
    irq_d = gen_w & (|mis_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      irq_q <= irq_d;
    end
  end

  assign rdata = rd_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [WORD_W-1:0]   wdata,
  input logic [WORD_W-1:0]   rdata,
  input logic                irq_o,
  input logic                gen_w,
  input logic [NUM_PINS-1:0] mode_w,
  input logic [NUM_PINS-1:0] hit_w,
  input logic [NUM_PINS-1:0] raw_w
);
  p_gen_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gen_w));

  p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_w & ~$past(raw_w) & ~$past(mode_w)) == '0));

  p_clear_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_CLR)) |=>
      ((raw_w[WORD_W-1:0] & $past(wdata) & ~$past(hit_w[WORD_W-1:0])) == '0));

  p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_w & $past(hit_w)) == $past(hit_w)));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .gen_w(gen_w),
  .mode_w(mode_w), .hit_w(hit_w), .raw_w(raw_w)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pins;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // behavioural reference
  logic [63:0] m_s1, m_s2, m_prev, m_typ, m_both, m_pol, m_mask, m_raw;
  logic        m_en, m_irq;
  logic [31:0] m_rdata;

  function automatic logic [63:0] m_mis();
    return m_mask & ((m_typ & m_raw) | (~m_typ & ~(m_s2 ^ m_pol)));
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [63:0] v;
    case ({a[7:3], 3'b000})
      8'h00: return (a == 8'h00) ? {31'b0, m_en} : 32'h0;
      8'h10: v = m_typ;
      8'h18: v = m_both;
      8'h20: v = m_pol;
      8'h28: v = m_mask;
      8'h38: v = m_raw;
      8'h40: v = m_mis();
      8'h48: v = m_s2;
      default: return 32'h0;
    endcase
    if (a[1:0] != 2'b00) return 32'h0;
    return a[2] ? v[63:32] : v[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_typ = '0; m_both = '0;
      m_pol = '0; m_mask = '0; m_raw = '0; m_en = 1'b0; m_irq = 1'b0;
      m_rdata = '0;
    end else begin
      logic [63:0] rise, fall, hit, clr;
      logic        irq_n;
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      hit  = m_typ & ((m_both & (rise | fall)) | (~m_both & m_pol & rise) |
                      (~m_both & ~m_pol & fall));
      clr = '0;
      if (wr_en && addr == 8'h30) clr[31:0]  = wdata;
      if (wr_en && addr == 8'h34) clr[63:32] = wdata;
      irq_n = m_en & (|m_mis());
      if (rd_en) m_rdata = m_read(addr);
      m_raw = (m_raw & ~clr) | hit;
      m_irq = irq_n;
      if (wr_en) begin
        case (addr)
          8'h00: m_en = wdata[0];
          8'h10: m_typ[31:0]   = wdata;  8'h14: m_typ[63:32]  = wdata;
          8'h18: m_both[31:0]  = wdata;  8'h1C: m_both[63:32] = wdata;
          8'h20: m_pol[31:0]   = wdata;  8'h24: m_pol[63:32]  = wdata;
          8'h28: m_mask[31:0]  = wdata;  8'h2C: m_mask[63:32] = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  // per-cycle comparison against the reference (R12 irq timing, R13 read path)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      checks++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL R12 irq_o act=%b exp=%b t=%0t", irq_o, m_irq, $time);
      end
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL R13 rdata act=%h exp=%h t=%0t", rdata, m_rdata, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s irq_o act=%b exp=%b", tag, irq_o, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    irq_chk(1'b0, "R1");
    for (int a = 0; a <= 'h4C; a += 4) rd_chk(8'(a), 32'h0, "R1");

    // pins 0-3 edge, pin1 dual, pins 0/2/4 high polarity, pin3 falling, pin4 level
    wr(8'h10, 32'h0000_000F);
    wr(8'h18, 32'h0000_0002);
    wr(8'h20, 32'h0000_0015);
    wr(8'h28, 32'h0000_001F);
    wr(8'h00, 32'h1);
    idle(3);
    irq_chk(1'b0, "R6");

    pins[3:0] = 4'hF;
    idle(5);
    rd_chk(8'h38, 32'h7, "R5");
    rd_chk(8'h40, 32'h7, "R9");
    irq_chk(1'b1, "R12");
    wr(8'h30, 32'h0);
    rd_chk(8'h38, 32'h7, "R7");
    rd_chk(8'h30, 32'h0, "R7");
    wr(8'h30, 32'h7);
    idle(2);
    rd_chk(8'h38, 32'h0, "R7");
    irq_chk(1'b0, "R12");

    pins[3:0] = 4'h0;
    idle(5);
    rd_chk(8'h38, 32'hA, "R4");
    wr(8'h30, 32'hF);

    pins[4] = 1'b1;
    idle(5);
    rd_chk(8'h38, 32'h0, "R8");
    rd_chk(8'h40, 32'h10, "R3");
    irq_chk(1'b1, "R3");

    wr(8'h00, 32'h0);
    idle(2);
    irq_chk(1'b0, "R2");
    rd_chk(8'h40, 32'h10, "R2");
    rd_chk(8'h00, 32'h0, "R2");
    wr(8'h00, 32'h1);
    idle(2);
    irq_chk(1'b1, "R2");

    wr(8'h28, 32'h0000_000F);
    idle(2);
    rd_chk(8'h40, 32'h0, "R6");
    irq_chk(1'b0, "R6");
    pins[4] = 1'b0;

    pins[63:32] = 32'hA5A5_0000;
    idle(5);
    rd_chk(8'h4C, 32'hA5A5_0000, "R10");
    rd_chk(8'h48, 32'h0, "R10");

    wr(8'h14, 32'h1);
    wr(8'h24, 32'h1);
    wr(8'h2C, 32'h1);
    pins[32] = 1'b1;
    idle(5);
    rd_chk(8'h3C, 32'h1, "R3");
    rd_chk(8'h44, 32'h1, "R9");
    irq_chk(1'b1, "R12");
    wr(8'h34, 32'h1);
    idle(2);
    irq_chk(1'b0, "R7");

    // edge on pin0 detected in the same cycle as a clear write to it
    pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h30; wdata = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    idle(2);
    rd_chk(8'h38, 32'h1, "R11");

    rd_chk(8'hFC, 32'h0, "R13");
    idle(3);
    finish_run();
  end
endmodule